// File: doc/BRIEF.md
# Dual-Channel Serial Register and Interrupt Controller

This block is the host-side register file of a two-channel asynchronous serial controller. A byte-wide bus reaches, for each channel, a control port and a data port. Configuration and status registers sit behind the control port and are reached indirectly. A pointer selects the register, it is loaded by a first control write, and it falls back to zero after the next control access. Shifting, bit timing and modem pins live elsewhere. Received bytes enter on a one-cycle valid strobe per channel, and transmitted bytes leave on a one-cycle valid strobe.

Each channel tracks a receive and a transmit interrupt, each with a pending flag and an under-service flag. Receive service outranks transmit. The two channels share one interrupt vector, whose encoding follows a status-high bit in a shared configuration register. They also share an interrupt-pending register and a level interrupt output. Software can reset either channel or both through the same shared register.

The register pointer of each channel is a two-state machine. In state PH_CMD the next control write is a command or a pointer load. The transition PH_CMD to PH_SEL happens when that write loads a nonzero pointer. In PH_CMD a read, or a write that loads pointer zero, stays in PH_CMD. The transition PH_SEL to PH_CMD happens on any control read or write. The same return happens at once when the channel is reset.

Top module: `dsio_regif`

## Requirements
- R1: Address bit 0 selects the port (0 control, 1 data). Address bit 1 selects the channel (1 channel A, 0 channel B). Accesses to one channel leave the other channel's registers unchanged.
- R2: In PH_CMD, a control write loads pointer bits 2:0 from data bits 2:0. If data bits 5:3 equal 001, pointer bit 3 is set as well, which reaches registers 8 to 15. The next control write goes to the pointed register, and the next control read returns the pointed read register.
- R3: Every control read, and every control write made in PH_SEL, returns the pointer to zero, so the following control read returns read register 0.
- R4: After reset, read register 0 of each channel is 0x44 (bit 6 underrun, bit 2 transmit empty). Read register 1 is 0x07. The vector (channel B read register 2) is 0x00. The pending register (channel A read register 3) is 0x00. The interrupt output is low.
- R5: A data write raises the channel's transmit pending flag. When write register 5 bit 3 is set, the byte appears on tx_data with tx_valid high for the one cycle after the write edge. Otherwise tx_valid stays low.
- R6: A received byte is taken only when write register 3 bit 0 is set and Rx-available (read register 0 bit 0) is clear. rx_busy is high exactly when that condition fails. A data read returns the last taken byte, clears Rx-available and clears the receive interrupt.
- R7: The vector is read at channel B read register 2, and channel A read register 2 reads 0x00. With write register 9 bit 4 clear the codes are: none 0x06, A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00. With it set they are: none 0x60, A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00. If both channels update the vector in one cycle, channel A's code is kept.
- R8: The pending register reads, at channel A read register 3: bit 0 B external (always 0), bit 1 B transmit, bit 2 B receive, bit 3 A external (always 0), bit 4 A transmit, bit 5 A receive. Channel B read register 3 reads 0x00. A transmit bit is set only if write register 1 bit 1 is set when the transmit interrupt enters service.
- R9: A transmit interrupt enters service, and writes the vector, only while no receive interrupt is under service. Command 111 (data bits 5:3) clears receive-under-service if it is set, and then re-raises a pending transmit interrupt. Otherwise the command clears transmit-under-service.
- R10: Command 101 clears the transmit pending and under-service flags and writes the no-interrupt vector. If a receive interrupt is still pending, it is then asserted again.
- R11: The interrupt output is high when, for either channel, any of three terms holds. The terms are: write register 1 bit 1 set with transmit pending; write register 1 bits 4:3 equal to 01 or 10 with receive pending; write register 15 bit 7 set with break status.
- R12: A brk_set pulse sets a sticky break status at read register 0 bit 7. After reset, write register 15 bit 7 is set, so break alone drives the interrupt.
- R13: A write to write register 9 with bits 7:6 = 01 resets channel B and the vector. Bits 10 reset channel A. Bits 11 reset both and clear the status-high bit. Bits 00 store bit 4 as status-high.
- R14: Values written to write registers 12 and 13 read back at read registers 12 and 13 of the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Bit 0 port (data/control), bit 1 channel (A/B) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data during a read access, else 0 |
| rx_valid | input | 2 | Received byte strobe, index 1 channel A, 0 channel B |
| rx_data | input | 16 | Received bytes, bits 15:8 channel A |
| rx_busy | output | 2 | High when the channel would refuse a byte |
| brk_set | input | 2 | Break detected pulse per channel |
| tx_valid | output | 2 | Transmit byte strobe per channel |
| tx_data | output | 16 | Transmit bytes, bits 15:8 channel A |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is combinational during the access cycle, so reads are sampled 1 ns after driving, well before the committing edge. Every side effect of an access or of a received byte is committed at that edge. The flags, vector, pending register, rx_busy and irq are therefore due 1 ns after it, and the bench compares them there against its own model. tx_valid rises at the write edge and lasts one cycle, so it is sampled just after that edge and never later. rx_busy is sampled mid-cycle before the strobe is applied, so the check sees the state that decides acceptance.

// File: rtl/dsio_pkg.sv
package dsio_pkg;
    localparam int DW  = 8;   // bus and register width
    localparam int NCH = 2;   // channels, index 1 = A, 0 = B
    localparam int PW  = 4;   // register pointer width

    localparam logic [2:0] CMD_HIGH   = 3'b001;
    localparam logic [2:0] CMD_CLR_TX = 3'b101;
    localparam logic [2:0] CMD_IUS    = 3'b111;

    typedef enum logic {PH_CMD, PH_SEL} ptr_ph_t;
    typedef enum logic [1:0] {EV_NONE, EV_QUIET, EV_RX, EV_TX} vec_ev_t;

    typedef struct packed {
        logic rxp;
        logic txp;
        logic rxus;
        logic txus;
        logic ipr;
        logic ipt;
    } flags_t;

    function automatic void f_set_rx(inout flags_t f, inout vec_ev_t ev);
        f.rxp  = 1'b1;
        f.rxus = 1'b1;
        f.ipr  = 1'b1;
        ev     = EV_RX;
    endfunction

    function automatic void f_set_tx(inout flags_t f, inout vec_ev_t ev, input logic txie);
        f.txp = 1'b1;
        if (!f.rxus) begin
            f.txus = 1'b1;
            if (txie) f.ipt = 1'b1;
            ev = EV_TX;
        end
    endfunction

    function automatic void f_clr_rx(inout flags_t f, inout vec_ev_t ev, input logic txie);
        f.rxp  = 1'b0;
        f.rxus = 1'b0;
        f.ipr  = 1'b0;
        ev     = EV_QUIET;
        if (f.txp) f_set_tx(f, ev, txie);
    endfunction

    function automatic void f_clr_tx(inout flags_t f, inout vec_ev_t ev);
        f.txp  = 1'b0;
        f.txus = 1'b0;
        f.ipt  = 1'b0;
        ev     = EV_QUIET;
        if (f.rxp) f_set_rx(f, ev);
    endfunction

    function automatic void f_ius(inout flags_t f, inout vec_ev_t ev, input logic txie);
        if (f.rxus) begin
            f.rxus = 1'b0;
            if (f.txp) f_set_tx(f, ev, txie);
        end else if (f.txus) begin
            f.txus = 1'b0;
        end
    endfunction

    function automatic logic [DW-1:0] vec_code(vec_ev_t ev, logic is_a, logic hi);
        logic [DW-1:0] v;
        unique case (ev)
            EV_QUIET: v = hi ? 8'h60 : 8'h06;
            EV_RX:    v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            EV_TX:    v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default:  v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/dsio_bus_dec.sv
module dsio_bus_dec
    import dsio_pkg::*;
(
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    output logic [NCH-1:0] ctl_wr,
    output logic [NCH-1:0] ctl_rd,
    output logic [NCH-1:0] dat_wr,
    output logic [NCH-1:0] dat_rd
);
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        logic hit;
        assign hit       = bus_sel && (bus_addr[1] == 1'(g));
        assign ctl_wr[g] = hit &&  bus_wr && !bus_addr[0];
        assign ctl_rd[g] = hit && !bus_wr && !bus_addr[0];
        assign dat_wr[g] = hit &&  bus_wr &&  bus_addr[0];
        assign dat_rd[g] = hit && !bus_wr &&  bus_addr[0];
    end
endmodule

// File: rtl/dsio_chan.sv
module dsio_chan
    import dsio_pkg::*;
#(
    parameter bit IS_A = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] wdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          brk_set,
    input  logic [DW-1:0] vec_in,
    input  logic [5:0]    ipend_in,
    output logic [DW-1:0] ctl_rdata,
    output logic [DW-1:0] dat_rdata,
    output logic          rx_busy,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          wr9_we,
    output vec_ev_t       ev,
    output logic [2:0]    ip3,
    output logic          irq_term
);
    ptr_ph_t       ph, ph_n;
    logic [PW-1:0] ptr, ptr_n, ep;
    flags_t        fl, fl_n;
    vec_ev_t       ev_n;
    logic          rxav, rx_acc;
    logic [DW-1:0] rxbuf, brgl, brgh;
    logic          txie, rxen, txen, brkie, brk;
    logic [1:0]    rxmode;
    logic [2:0]    cmd;
    logic          sel_wr;

    assign cmd    = wdata[5:3];
    assign sel_wr = ctl_wr && (ph == PH_SEL);
    assign rx_acc = rx_valid && rxen && !rxav;
    assign ep     = (ph == PH_SEL) ? ptr : '0;

    // pointer state machine and interrupt flag next state
    always_comb begin
        ph_n  = ph;
        ptr_n = ptr;
        fl_n  = fl;
        ev_n  = EV_NONE;
        if (ctl_rd) begin
            ph_n = PH_CMD;
        end else if (ctl_wr) begin
            unique case (ph)
                PH_CMD: begin
                    ptr_n = {cmd == CMD_HIGH, wdata[2:0]};
                    ph_n  = (ptr_n != '0) ? PH_SEL : PH_CMD;
                    if (cmd == CMD_CLR_TX)   f_clr_tx(fl_n, ev_n);
                    else if (cmd == CMD_IUS) f_ius(fl_n, ev_n, txie);
                end
                PH_SEL: ph_n = PH_CMD;
            endcase
        end
        if (dat_wr) f_set_tx(fl_n, ev_n, txie);
        if (dat_rd) f_clr_rx(fl_n, ev_n, txie);
        if (rx_acc) f_set_rx(fl_n, ev_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= PH_CMD;
            ptr <= '0;
            fl  <= '0;
        end else if (soft_rst) begin
            ph  <= PH_CMD;
            ptr <= '0;
            fl  <= '0;
        end else begin
            ph  <= ph_n;
            ptr <= ptr_n;
            fl  <= fl_n;
        end
    end

    // configuration, receive buffer and transmit strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txie <= 1'b0; rxmode <= 2'b00; rxen <= 1'b0; txen <= 1'b0;
            brkie <= 1'b1; brk <= 1'b0; brgl <= '0; brgh <= '0;
            rxav <= 1'b0; rxbuf <= '0; tx_valid <= 1'b0; tx_data <= '0;
        end else if (soft_rst) begin
            txie <= 1'b0; rxmode <= 2'b00; rxen <= 1'b0; txen <= 1'b0;
            brkie <= 1'b1; brk <= 1'b0; brgl <= '0; brgh <= '0;
            rxav <= 1'b0; rxbuf <= '0; tx_valid <= 1'b0;
        end else begin
            if (sel_wr) begin
                case (ptr)
                    4'd1:  begin txie <= wdata[1]; rxmode <= wdata[4:3]; end
                    4'd3:  rxen  <= wdata[0];
                    4'd5:  txen  <= wdata[3];
                    4'd12: brgl  <= wdata;
                    4'd13: brgh  <= wdata;
                    4'd15: brkie <= wdata[7];
                    default: ;
                endcase
            end
            if (brk_set) brk <= 1'b1;
            if (rx_acc) begin
                rxav  <= 1'b1;
                rxbuf <= rx_data;
            end else if (dat_rd) begin
                rxav  <= 1'b0;
            end
            tx_valid <= dat_wr && txen;
            if (dat_wr) tx_data <= wdata;
        end
    end

    always_comb begin
        case (ep)
            4'd0:    ctl_rdata = {brk, 1'b1, 3'b000, 1'b1, 1'b0, rxav};
            4'd1:    ctl_rdata = 8'h07;
            4'd2:    ctl_rdata = IS_A ? 8'h00 : vec_in;
            4'd3:    ctl_rdata = IS_A ? {2'b00, ipend_in} : 8'h00;
            4'd12:   ctl_rdata = brgl;
            4'd13:   ctl_rdata = brgh;
            default: ctl_rdata = 8'h00;
        endcase
    end

    assign dat_rdata = rxbuf;
    assign rx_busy   = !(rxen && !rxav);
    assign wr9_we    = sel_wr && (ptr == 4'd9);
    assign ev        = soft_rst ? EV_NONE : ev_n;
    assign ip3       = {fl.ipr, fl.ipt, 1'b0};
    assign irq_term  = (txie && fl.txp) ||
                       (((rxmode == 2'b01) || (rxmode == 2'b10)) && fl.rxp) ||
                       (brkie && brk);

    p_ptr_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_wr || ctl_rd) && ph == PH_SEL) |=> (ph == PH_CMD));

    p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxav) |-> $past(rx_valid && rxen));

    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_busy && !soft_rst) |=> $stable(rxbuf));

    p_tx_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !soft_rst) |=> fl.txp);
endmodule

// File: rtl/dsio_irq_ctrl.sv
module dsio_irq_ctrl
    import dsio_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr9_we,
    input  logic [1:0]     wr9_rst,
    input  logic           wr9_hi,
    input  vec_ev_t        ev_b,
    input  vec_ev_t        ev_a,
    input  logic [NCH-1:0] term,
    output logic [DW-1:0]  vec,
    output logic [NCH-1:0] soft_rst,
    output logic           irq
);
    logic          hi;
    logic [DW-1:0] vec_n;

    assign soft_rst = wr9_we ? wr9_rst : '0;

    always_comb begin
        vec_n = vec;
        if (ev_b != EV_NONE) vec_n = vec_code(ev_b, 1'b0, hi);
        if (ev_a != EV_NONE) vec_n = vec_code(ev_a, 1'b1, hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi  <= 1'b0;
            vec <= '0;
        end else begin
            if (wr9_we && wr9_rst == 2'b00) hi <= wr9_hi;
            else if (soft_rst == 2'b11)     hi <= 1'b0;
            vec <= soft_rst[0] ? '0 : vec_n;
        end
    end

    assign irq = |term;

    p_vec_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

    p_soft_vec_r13: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst[0] |=> (vec == 8'h00));
endmodule

// File: rtl/dsio_regif.sv
module dsio_regif
    import dsio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    rx_valid,
    input  logic [NCH*DW-1:0] rx_data,
    output logic [NCH-1:0]    rx_busy,
    input  logic [NCH-1:0]    brk_set,
    output logic [NCH-1:0]    tx_valid,
    output logic [NCH*DW-1:0] tx_data,
    output logic              irq
);
    logic [NCH-1:0]         ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic [NCH-1:0]         wr9_we_c, soft_rst, term;
    logic [NCH-1:0][DW-1:0] ctl_rdata, dat_rdata;
    logic [NCH-1:0][2:0]    ip3;
    vec_ev_t                ev [NCH];
    logic [DW-1:0]          vec;
    logic [5:0]             ipend;

    dsio_bus_dec i_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ctl_wr  (ctl_wr),
        .ctl_rd  (ctl_rd),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd)
    );

    assign ipend = {ip3[1], ip3[0]};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dsio_chan #(.IS_A(g == 1)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst[g]),
            .ctl_wr   (ctl_wr[g]),
            .ctl_rd   (ctl_rd[g]),
            .dat_wr   (dat_wr[g]),
            .dat_rd   (dat_rd[g]),
            .wdata    (bus_wdata),
            .rx_valid (rx_valid[g]),
            .rx_data  (rx_data[g*DW +: DW]),
            .brk_set  (brk_set[g]),
            .vec_in   (vec),
            .ipend_in (ipend),
            .ctl_rdata(ctl_rdata[g]),
            .dat_rdata(dat_rdata[g]),
            .rx_busy  (rx_busy[g]),
            .tx_valid (tx_valid[g]),
            .tx_data  (tx_data[g*DW +: DW]),
            .wr9_we   (wr9_we_c[g]),
            .ev       (ev[g]),
            .ip3      (ip3[g]),
            .irq_term (term[g])
        );
    end

    dsio_irq_ctrl i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr9_we  (|wr9_we_c),
        .wr9_rst (bus_wdata[7:6]),
        .wr9_hi  (bus_wdata[4]),
        .ev_b    (ev[0]),
        .ev_a    (ev[1]),
        .term    (term),
        .vec     (vec),
        .soft_rst(soft_rst),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr)
            bus_rdata = bus_addr[0] ? dat_rdata[bus_addr[1]] : ctl_rdata[bus_addr[1]];
    end
endmodule

// File: tb/test_dsio_regif.sv
module test_dsio_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'b00;
    logic [7:0]  bus_wdata = 8'h00, bus_rdata;
    logic [1:0]  rx_valid = 2'b00, rx_busy, brk_set = 2'b00, tx_valid;
    logic [15:0] rx_data = 16'h0, tx_data;
    logic        irq;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    dsio_regif i_dsio_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_busy(rx_busy),
        .brk_set(brk_set), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // reference model, index 1 = A, 0 = B
    logic m_rxp[2], m_txp[2], m_rxus[2], m_txus[2], m_ipr[2], m_ipt[2];
    logic m_txie[2], m_rxen[2], m_txen[2], m_brkie[2], m_brk[2], m_rxav[2];
    logic [1:0] m_rxmode[2];
    logic [7:0] m_rxbuf[2];
    logic [7:0] m_vec = 8'h00;
    logic       m_hi = 1'b0;

    function automatic logic [7:0] vcode(int ev, int c, logic hi);
        if (ev == 1) return hi ? 8'h60 : 8'h06;
        if (ev == 2) return (c == 1) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
        return (c == 1) ? (hi ? 8'h10 : 8'h08) : 8'h00;
    endfunction

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int c = 0; c < 2; c++)
            r |= (m_txie[c] & m_txp[c]) |
                 (((m_rxmode[c] == 2'b01) || (m_rxmode[c] == 2'b10)) & m_rxp[c]) |
                 (m_brkie[c] & m_brk[c]);
        return r;
    endfunction

    function automatic logic [7:0] m_ipend();
        return {2'b00, m_ipr[1], m_ipt[1], 1'b0, m_ipr[0], m_ipt[0], 1'b0};
    endfunction

    task automatic m_reset(int c);
        m_rxp[c] = 0; m_txp[c] = 0; m_rxus[c] = 0; m_txus[c] = 0; m_ipr[c] = 0; m_ipt[c] = 0;
        m_txie[c] = 0; m_rxen[c] = 0; m_txen[c] = 0; m_brkie[c] = 1; m_brk[c] = 0;
        m_rxav[c] = 0; m_rxmode[c] = 2'b00; m_rxbuf[c] = 8'h00;
    endtask

    task automatic m_set_rx(int c);
        m_rxp[c] = 1; m_rxus[c] = 1; m_ipr[c] = 1; m_vec = vcode(2, c, m_hi);
    endtask

    task automatic m_set_tx(int c);
        m_txp[c] = 1;
        if (!m_rxus[c]) begin
            m_txus[c] = 1;
            if (m_txie[c]) m_ipt[c] = 1;
            m_vec = vcode(3, c, m_hi);
        end
    endtask

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic acc(logic wr, int c, logic dat, logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = {c[0], dat}; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wreg(int c, int r, logic [7:0] v);
        logic [7:0] d;
        acc(1, c, 0, (r >= 8) ? (8'h08 | 8'(r % 8)) : 8'(r), d);
        acc(1, c, 0, v, d);
        case (r)
            1: begin m_txie[c] = v[1]; m_rxmode[c] = v[4:3]; end
            3: m_rxen[c] = v[0];
            5: m_txen[c] = v[3];
            15: m_brkie[c] = v[7];
            9: begin
                if (v[7:6] == 2'b00) m_hi = v[4];
                if (v[6]) begin m_reset(0); m_vec = 8'h00; end
                if (v[7]) m_reset(1);
                if (v[7:6] == 2'b11) m_hi = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic rreg(int c, int r, output logic [7:0] v);
        logic [7:0] d;
        if (r != 0) acc(1, c, 0, (r >= 8) ? (8'h08 | 8'(r % 8)) : 8'(r), d);
        acc(0, c, 0, 8'h00, v);
    endtask

    task automatic op_dwrite(int c, logic [7:0] v);
        logic [7:0] d;
        acc(1, c, 1, v, d);
        chk("R5 tx_valid", 16'(tx_valid[c]), 16'(m_txen[c]));
        if (m_txen[c]) chk("R5 tx_data", 16'(tx_data[c*8 +: 8]), 16'(v));
        m_set_tx(c);
    endtask

    task automatic op_dread(int c);
        logic [7:0] d;
        acc(0, c, 1, 8'h00, d);
        chk("R6 data read", 16'(d), 16'(m_rxbuf[c]));
        m_rxav[c] = 0;
        m_rxp[c] = 0; m_rxus[c] = 0; m_ipr[c] = 0; m_vec = vcode(1, c, m_hi);
        if (m_txp[c]) m_set_tx(c);
    endtask

    task automatic op_rx(int c, logic [7:0] v);
        @(negedge clk);
        chk("R6 rx_busy", 16'(rx_busy[c]), 16'(!(m_rxen[c] && !m_rxav[c])));
        rx_valid[c] = 1'b1; rx_data[c*8 +: 8] = v;
        @(posedge clk);
        #1 rx_valid = 2'b00;
        if (m_rxen[c] && !m_rxav[c]) begin
            m_rxav[c] = 1; m_rxbuf[c] = v; m_set_rx(c);
        end
    endtask

    task automatic op_cmd(int c, logic [7:0] v);
        logic [7:0] d;
        acc(1, c, 0, v, d);
        if (v[5:3] == 3'b101) begin
            m_txp[c] = 0; m_txus[c] = 0; m_ipt[c] = 0; m_vec = vcode(1, c, m_hi);
            if (m_rxp[c]) m_set_rx(c);
        end else if (v[5:3] == 3'b111) begin
            if (m_rxus[c]) begin
                m_rxus[c] = 0;
                if (m_txp[c]) m_set_tx(c);
            end else if (m_txus[c]) m_txus[c] = 0;
        end
    endtask

    task automatic chk_state(string tag);
        logic [7:0] d;
        chk({tag, " R11 irq"}, 16'(irq), 16'(m_irq()));
        rreg(0, 2, d); chk({tag, " R7 vector"}, 16'(d), 16'(m_vec));
        rreg(1, 3, d); chk({tag, " R8 pending"}, 16'(d), 16'(m_ipend()));
        for (int c = 0; c < 2; c++) begin
            rreg(c, 0, d);
            chk({tag, " R6 status"}, 16'(d), 16'({m_brk[c], 5'b10001, 1'b0, m_rxav[c]}));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        m_reset(0); m_reset(1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4 reset state
        @(negedge clk);
        chk("R4 irq", 16'(irq), 16'h0);
        rreg(1, 0, d); chk("R4 RR0 A", 16'(d), 16'h44);
        rreg(0, 0, d); chk("R4 RR0 B", 16'(d), 16'h44);
        rreg(0, 1, d); chk("R4 RR1 B", 16'(d), 16'h07);
        rreg(0, 2, d); chk("R4 vector", 16'(d), 16'h00);
        rreg(1, 3, d); chk("R4 pending", 16'(d), 16'h00);

        // R2 point-high, R14 mirror, R1 channel select, R3 pointer return
        wreg(1, 12, 8'h5A);
        wreg(0, 12, 8'hA5);
        wreg(1, 13, 8'h3C);
        rreg(1, 12, d); chk("R2 R14 RR12 A", 16'(d), 16'h5A);
        rreg(0, 12, d); chk("R1 RR12 B", 16'(d), 16'hA5);
        rreg(1, 13, d); chk("R14 RR13 A", 16'(d), 16'h3C);
        acc(0, 1, 0, 8'h00, d); chk("R3 read after read", 16'(d), 16'h44);
        acc(1, 1, 0, 8'h0C, d); acc(1, 1, 0, 8'h77, d);
        acc(0, 1, 0, 8'h00, d); chk("R3 read after write", 16'(d), 16'h44);
        rreg(1, 12, d); chk("R2 RR12 rewritten", 16'(d), 16'h77);

        // R5 transmit
        wreg(1, 5, 8'h08);
        op_dwrite(1, 8'hC3);
        rreg(0, 2, d); chk("R7 A tx code", 16'(d), 16'h08);
        chk("R11 irq tx masked", 16'(irq), 16'h0);
        wreg(1, 1, 8'h02);
        @(negedge clk); chk("R11 irq tx enabled", 16'(irq), 16'h1);
        rreg(1, 3, d); chk("R8 tx bit not latched", 16'(d), 16'h00);
        op_cmd(1, 8'h28);
        rreg(0, 2, d); chk("R10 no-int code", 16'(d), 16'h06);
        op_dwrite(0, 8'h11);
        chk("R5 tx disabled B", 16'(tx_valid), 16'h0);
        rreg(1, 3, d); chk("R8 B tx bit", 16'(d), 16'h00);
        op_cmd(0, 8'h28);

        // R6 receive gating
        op_rx(0, 8'h99);
        rreg(0, 0, d); chk("R6 rx refused", 16'(d), 16'h44);
        wreg(0, 3, 8'h01);
        op_rx(0, 8'h77);
        op_rx(0, 8'h12);
        rreg(0, 0, d); chk("R6 rx available", 16'(d), 16'h45);
        op_dread(0);
        chk_state("R6");

        // R9 priority, R10 re-assert, R8 pending bits
        wreg(1, 3, 8'h01);
        wreg(1, 1, 8'h12);
        op_rx(1, 8'h55);
        rreg(0, 2, d); chk("R7 A rx code", 16'(d), 16'h0C);
        op_dwrite(1, 8'h01);
        rreg(0, 2, d); chk("R9 tx held off", 16'(d), 16'h0C);
        op_cmd(1, 8'h38);
        rreg(0, 2, d); chk("R9 ius raises tx", 16'(d), 16'h08);
        op_dread(1);
        op_cmd(1, 8'h28);
        op_rx(1, 8'h66);
        op_cmd(1, 8'h28);
        rreg(0, 2, d); chk("R10 rx re-asserted", 16'(d), 16'h0C);
        rreg(1, 3, d); chk("R8 A rx bit", 16'(d), 16'h20);
        wreg(1, 1, 8'h18);
        @(negedge clk); chk("R11 rx mode 11 masked", 16'(irq), 16'h0);
        wreg(1, 1, 8'h08);
        @(negedge clk); chk("R11 rx mode 01", 16'(irq), 16'h1);
        chk_state("R9");

        // R7 status-high codes
        wreg(0, 9, 8'h10);
        op_rx(0, 8'h21);
        rreg(0, 2, d); chk("R7 hi B rx", 16'(d), 16'h20);
        rreg(1, 2, d); chk("R7 RR2 A", 16'(d), 16'h00);
        op_dread(0);
        rreg(0, 2, d); chk("R7 hi none", 16'(d), 16'h60);
        chk_state("R7");

        // R13 resets
        wreg(1, 9, 8'h40);
        rreg(0, 0, d); chk("R13 B reset", 16'(d), 16'h44);
        rreg(1, 0, d); chk("R13 A kept", 16'(d), 16'h45);
        rreg(0, 2, d); chk("R13 vector cleared", 16'(d), 16'h00);
        chk_state("R13");
        wreg(0, 9, 8'hC0);
        chk_state("R13 both");

        // R12 break
        @(negedge clk); brk_set = 2'b01;
        @(posedge clk); #1 brk_set = 2'b00;
        rreg(0, 0, d); chk("R12 break status", 16'(d), 16'hC4);
        chk("R12 break irq", 16'(irq), 16'h1);
        m_brk[0] = 1;
        wreg(0, 15, 8'h00);
        @(negedge clk); chk("R12 break masked", 16'(irq), 16'h0);
        wreg(0, 9, 8'hC0);

        // constrained random against the model
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            int c, op;
            c  = int'($urandom_range(1, 0));
            op = int'($urandom_range(9, 0));
            case (op)
                0, 1: op_dwrite(c, 8'($urandom));
                2:    op_dread(c);
                3, 4: op_rx(c, 8'($urandom));
                5:    op_cmd(c, 8'h28);
                6:    op_cmd(c, 8'h38);
                7: begin
                    logic [7:0] cfg[6] = '{8'h00, 8'h02, 8'h08, 8'h10, 8'h12, 8'h1A};
                    wreg(c, 1, cfg[$urandom_range(5, 0)]);
                end
                8: begin wreg(c, 3, 8'($urandom_range(1, 0))); wreg(c, 5, 8'h08); end
                default: wreg(c, 9, ($urandom_range(1, 0) != 0) ? 8'h10 : 8'h00);
            endcase
            chk_state("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule